// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is an I2C bus master that works one byte at a time under software control. Software writes a byte into a transmit register and then writes a command word. The command word may set any mix of the start, stop, write, read and acknowledge bits. The core runs those bits in a fixed bus order: start first, then the data byte, then the ninth (acknowledge) clock, then stop. A driver therefore needs only one command write for the common steps of a transfer: open and send, send and close, or read and close.

The block has three layers.

- A register block holds the divider, enable, transmit, receive and pending-command registers.
- A sequencer walks the states `SEQ_IDLE`, `SEQ_START`, `SEQ_DATA`, `SEQ_ACK` and `SEQ_STOP`. It takes the path IDLE→START when start is set, and START/IDLE→DATA when write or read is set. It moves DATA→ACK after eight bits, ACK→STOP when stop is set, and otherwise ends in IDLE.
- A bit engine splits each bus bit into the quarter phases `PH_A`, `PH_B`, `PH_C` and `PH_D`. It leaves `PH_IDLE` on a request, advances one phase on each divider tick, and returns to `PH_IDLE` after `PH_D`.

Both bus lines are open-drain style: an output value of 1 releases the line. The bench, or the pad outside the block, forms the wired-AND of the lines and feeds the SDA level back on `sda_in`.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, every readable field is zero: divider, enable, busy flag, received-acknowledge flag, transmit, receive and pending command. Both bus lines are released (1).
- R2: While the enable bit (configuration bit 15 at address 0) is 0, both bus outputs stay 1 even when a command is pending. The pending command is kept and can be read back at address 3.
- R3: Writing 0 to the command register (address 3) discards a pending command, so that no bus activity follows when the core is later enabled.
- R4: A command with the start bit (bit 0) and the write bit (bit 3) makes SDA fall while SCL is high. It then shifts out the transmit byte (address 1, bits 7:0), MSB first, with one SCL rising edge per bit, and then gives a ninth clock.
- R5: Within a byte, consecutive SCL rising edges are 4×(D+1)+1 system clocks apart, where D is the divider in configuration bits 7:0. Each quarter phase lasts D+1 clocks, and one clock is spent handing over between bits.
- R6: After a write, the received-acknowledge flag (status bit 13) holds the SDA level sampled during the ninth clock: 0 if the slave pulled SDA low, 1 if it did not.
- R7: When the stop bit (bit 1) is set together with write, the core sends the byte and the acknowledge clock, then makes SDA rise while SCL is high, and leaves both lines at 1.
- R8: When stop, read (bit 2) and ack (bit 4) are set together, the core clocks in one byte into the receive register (address 2), drives the ninth bit as the ack bit (1 = no-acknowledge, 0 = acknowledge), then makes a stop condition.
- R9: A start issued while the previous command left SCL low produces a repeated start. SDA is released while SCL is low, SCL rises, and SDA falls with no stop condition in between. SCL is then held low when the command ends.
- R10: The busy flag (status bit 14) reads 1 from the cycle after a command write until the last phase of that command ends, and 0 after that.
- R11: The SDA output changes while SCL is high only in the middle phase of a start or a stop.
- R12: The receive register changes only when a read's acknowledge clock completes. Writes to address 2, and to the busy and acknowledge bit positions at address 0, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 config/status, 1 transmit, 2 receive, 3 command |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register, combinational |
| sda_in | input | 1 | Level of the SDA line as seen on the bus |
| scl_out | output | 1 | SCL drive, 1 = released, 0 = pull low |
| sda_out | output | 1 | SDA drive, 1 = released, 0 = pull low |

## Verification
The assertions watch four properties on every cycle. The lines are quiet while the core is disabled. SDA moves under a high SCL only inside a start or stop phase. Busy is already up when the sequencer leaves idle. The receive register moves only after a completed read. Bus-level results can only be shown by the bench's scenarios against its slave model: the byte that arrives at the slave, the acknowledge value captured in either direction, the SCL period for each divider value, whether a start is a repeated start, and the order of combined commands.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int CMD_W  = 5;

    localparam logic [1:0] ADR_CFG = 2'd0;
    localparam logic [1:0] ADR_TX  = 2'd1;
    localparam logic [1:0] ADR_RX  = 2'd2;
    localparam logic [1:0] ADR_CMD = 2'd3;

    localparam int EN_POS   = 15;
    localparam int BUSY_POS = 14;
    localparam int NACK_POS = 13;

    typedef enum logic [1:0] {BIT_START, BIT_STOP, BIT_WR, BIT_RD} bit_op_e;
    typedef enum logic [2:0] {PH_IDLE, PH_A, PH_B, PH_C, PH_D} bit_ph_e;
    typedef enum logic [2:0] {SEQ_IDLE, SEQ_START, SEQ_DATA, SEQ_ACK, SEQ_STOP} seq_e;

    // command word bit 0 start, 1 stop, 2 read, 3 write, 4 ack level
    typedef struct packed {
        logic ack;
        logic wr;
        logic rd;
        logic stop;
        logic start;
    } cmd_t;
endpackage

// File: rtl/i2cbm_qdiv.sv
module i2cbm_qdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);
endmodule

// File: rtl/i2cbm_bit_fsm.sv
module i2cbm_bit_fsm
    import i2cbm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    tick,
    input  logic    req,
    input  bit_op_e op,
    input  logic    din,
    input  logic    sda_in,
    output logic    idle,
    output logic    done,
    output logic    dout,
    output logic    scl_q,
    output logic    sda_q,
    output logic    edge_ok
);
    bit_ph_e state, nxt;
    bit_op_e op_q;

    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE: if (req && en) nxt = PH_A;
            PH_A:    if (tick) nxt = PH_B;
            PH_B:    if (tick) nxt = PH_C;
            PH_C:    if (tick) nxt = PH_D;
            PH_D:    if (tick) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= BIT_START;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            dout  <= 1'b1;
        end else if (!en) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else if (state == PH_IDLE && req) begin
            op_q <= op;
            unique case (op)
                BIT_START: sda_q <= 1'b1;
                BIT_STOP:  begin scl_q <= 1'b0; sda_q <= 1'b0; end
                BIT_WR:    begin scl_q <= 1'b0; sda_q <= din;  end
                BIT_RD:    begin scl_q <= 1'b0; sda_q <= 1'b1; end
                default:   sda_q <= 1'b1;
            endcase
        end else if (tick) begin
            unique case (state)
                PH_A: scl_q <= 1'b1;
                PH_B: begin
                    dout <= sda_in;
                    if (op_q == BIT_START)     sda_q <= 1'b0;
                    else if (op_q == BIT_STOP) sda_q <= 1'b1;
                end
                PH_C: if (op_q != BIT_STOP) scl_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign idle    = (state == PH_IDLE);
    assign done    = (state == PH_D) && tick;
    assign edge_ok = (state == PH_C) && (op_q == BIT_START || op_q == BIT_STOP);
endmodule

// File: rtl/i2cbm_seq.sv
module i2cbm_seq
    import i2cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  cmd_t              cmd,
    input  logic [BYTE_W-1:0] tx,
    input  logic              eng_idle,
    input  logic              eng_done,
    input  logic              eng_dout,
    output logic              eng_req,
    output bit_op_e           eng_op,
    output logic              eng_din,
    output logic              active,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_load,
    output logic              ack_val
);
    localparam int CNT_W = $clog2(BYTE_W);

    seq_e              state, nxt;
    cmd_t              cmd_q;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_IDLE:
                if (go) begin
                    if (cmd.start)              nxt = SEQ_START;
                    else if (cmd.wr || cmd.rd)  nxt = SEQ_DATA;
                    else if (cmd.stop)          nxt = SEQ_STOP;
                end
            SEQ_START:
                if (eng_done) begin
                    if (cmd_q.wr || cmd_q.rd)   nxt = SEQ_DATA;
                    else if (cmd_q.stop)        nxt = SEQ_STOP;
                    else                        nxt = SEQ_IDLE;
                end
            SEQ_DATA:
                if (eng_done && bitcnt == CNT_W'(BYTE_W - 1)) nxt = SEQ_ACK;
            SEQ_ACK:
                if (eng_done) nxt = cmd_q.stop ? SEQ_STOP : SEQ_IDLE;
            SEQ_STOP:
                if (eng_done) nxt = SEQ_IDLE;
            default: nxt = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            shreg  <= '0;
            bitcnt <= '0;
        end else if (state == SEQ_IDLE && go) begin
            cmd_q  <= cmd;
            shreg  <= tx;
            bitcnt <= '0;
        end else if (state == SEQ_DATA && eng_done) begin
            shreg  <= {shreg[BYTE_W-2:0], eng_dout};
            bitcnt <= bitcnt + 1'b1;
        end
    end

    always_comb begin
        eng_op  = BIT_START;
        eng_din = 1'b1;
        unique case (state)
            SEQ_START: eng_op = BIT_START;
            SEQ_DATA: begin
                eng_op  = cmd_q.wr ? BIT_WR : BIT_RD;
                eng_din = shreg[BYTE_W-1];
            end
            SEQ_ACK: begin
                eng_op  = cmd_q.wr ? BIT_RD : BIT_WR;
                eng_din = cmd_q.ack;
            end
            SEQ_STOP: eng_op = BIT_STOP;
            default:  eng_op = BIT_START;
        endcase
    end

    assign active   = (state != SEQ_IDLE);
    assign eng_req  = active && eng_idle;
    assign rx_load  = (state == SEQ_ACK) && eng_done && !cmd_q.wr;
    assign rx_byte  = shreg;
    assign ack_load = (state == SEQ_ACK) && eng_done && cmd_q.wr;
    assign ack_val  = eng_dout;
endmodule

// File: rtl/i2cbm_regs.sv
module i2cbm_regs
    import i2cbm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              active,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ack_load,
    input  logic              ack_val,
    output logic              en,
    output logic [DIV_W-1:0]  div,
    output logic [BYTE_W-1:0] tx,
    output cmd_t              pend,
    output logic              go,
    output logic              busy,
    output logic [BYTE_W-1:0] rx_q
);
    logic nack_q;
    logic unused_wbits;

    assign unused_wbits = ^wdata[REG_W-2:DIV_W];

    assign go   = en && (|pend) && !active;
    assign busy = active || (|pend);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            div    <= '0;
            tx     <= '0;
            pend   <= '0;
            rx_q   <= '0;
            nack_q <= 1'b0;
        end else begin
            if (go)       pend   <= '0;
            if (rx_load)  rx_q   <= rx_byte;
            if (ack_load) nack_q <= ack_val;
            if (wr) begin
                unique case (addr)
                    ADR_CFG: begin
                        div <= wdata[DIV_W-1:0];
                        en  <= wdata[EN_POS];
                    end
                    ADR_TX:  tx   <= wdata[BYTE_W-1:0];
                    ADR_CMD: pend <= cmd_t'(wdata[CMD_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_CFG: begin
                rdata[DIV_W-1:0] = div;
                rdata[EN_POS]    = en;
                rdata[BUSY_POS]  = busy;
                rdata[NACK_POS]  = nack_q;
            end
            ADR_TX:  rdata[BYTE_W-1:0] = tx;
            ADR_RX:  rdata[BYTE_W-1:0] = rx_q;
            ADR_CMD: rdata[CMD_W-1:0]  = pend;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cbm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sda_in,
    output logic             scl_out,
    output logic             sda_out
);
    logic              cfg_en;
    logic [DIV_W-1:0]  cfg_div;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BYTE_W-1:0] rx_byte;
    cmd_t              pend;
    logic              go, busy;
    logic              seq_active, rx_load, ack_load, ack_val;
    logic              eng_req, eng_din, eng_idle, eng_done, eng_dout, eng_edge;
    bit_op_e           eng_op;
    logic              tick;

    i2cbm_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .active(seq_active),
        .rx_load(rx_load), .rx_byte(rx_byte), .ack_load(ack_load),
        .ack_val(ack_val), .en(cfg_en), .div(cfg_div), .tx(tx_q),
        .pend(pend), .go(go), .busy(busy), .rx_q(rx_q)
    );

    i2cbm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .cmd(pend), .tx(tx_q),
        .eng_idle(eng_idle), .eng_done(eng_done), .eng_dout(eng_dout),
        .eng_req(eng_req), .eng_op(eng_op), .eng_din(eng_din),
        .active(seq_active), .rx_load(rx_load), .rx_byte(rx_byte),
        .ack_load(ack_load), .ack_val(ack_val)
    );

    i2cbm_qdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(!eng_idle), .div(cfg_div), .tick(tick)
    );

    i2cbm_bit_fsm u_bit (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .tick(tick), .req(eng_req),
        .op(eng_op), .din(eng_din), .sda_in(sda_in), .idle(eng_idle),
        .done(eng_done), .dout(eng_dout), .scl_q(scl_out), .sda_q(sda_out),
        .edge_ok(eng_edge)
    );
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       scl_out,
    input logic       sda_out,
    input logic       edge_ok,
    input logic       active,
    input logic       busy,
    input logic [7:0] rx_q,
    input logic       rx_load
);
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_out && sda_out)); // R2

    AST_SDA_STILL_UNDER_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_out && $past(scl_out) && (sda_out != $past(sda_out))) |-> edge_ok); // R11

    AST_BUSY_BEFORE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (busy && $past(busy))); // R10

    AST_RX_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q != $past(rx_q)) |-> $past(rx_load)); // R12
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .scl_out(scl_out),
    .sda_out(sda_out), .edge_ok(eng_edge), .active(seq_active),
    .busy(busy), .rx_q(rx_q), .rx_load(rx_load)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        scl_out, sda_out, sda_bus, slave_sda;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // slave model state
    int        cyc = 0;
    int        bitcnt = -1;
    int        n_start = 0;
    int        n_stop = 0;
    int        rd_req = 0;
    int        rd_served = 0;
    int        t_rise1 = 0;
    int        period = 0;
    logic      p_scl = 1'b1;
    logic      p_sda = 1'b1;
    logic [7:0] tmp_byte = 8'd0;
    logic [7:0] cap_byte = 8'd0;
    logic      master_ack = 1'b1;
    logic [7:0] slave_tx = 8'd0;
    logic      slave_ack_drv = 1'b0;
    logic      reading;

    always #2 clk = ~clk;

    assign reading   = (rd_req > rd_served);
    assign slave_sda = (reading && bitcnt >= 0 && bitcnt < 8) ? slave_tx[3'(7 - bitcnt)]
                     : ((!reading && bitcnt == 8) ? slave_ack_drv : 1'b1);
    assign sda_bus   = sda_out & slave_sda;

    i2c_byte_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_bus),
        .scl_out(scl_out), .sda_out(sda_out)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (scl_out && p_scl && p_sda && !sda_bus) begin
            n_start <= n_start + 1;
            bitcnt  <= -1;
        end else if (scl_out && p_scl && !p_sda && sda_bus) begin
            n_stop <= n_stop + 1;
            bitcnt <= -1;
        end else if (scl_out && !p_scl) begin
            if (bitcnt >= 0 && bitcnt < 8) begin
                tmp_byte[3'(7 - bitcnt)] = sda_bus;
                if (bitcnt == 7) cap_byte <= tmp_byte;
            end
            if (bitcnt == 8) master_ack <= sda_bus;
            if (bitcnt == 1) t_rise1 <= cyc;
            if (bitcnt == 2) period <= cyc - t_rise1;
        end else if (!scl_out && p_scl) begin
            if (bitcnt == 8) begin
                bitcnt <= 0;
                if (reading) rd_served <= rd_served + 1;
            end else begin
                bitcnt <= bitcnt + 1;
            end
        end
        p_scl <= scl_out;
        p_sda <= sda_bus;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        int n = 0;
        do begin
            reg_read(2'd0, s);
            n++;
        end while (s[14] && n < 20000);
        if (n >= 20000) check("R10 busy never cleared", 32'(s[14]), 32'd0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // {divider, data byte, slave ack drive}
    localparam logic [23:0] VEC [4] = '{
        {8'd1, 8'hA5, 8'd0},
        {8'd3, 8'h3C, 8'd1},
        {8'd0, 8'hFF, 8'd0},
        {8'd5, 8'h00, 8'd1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R10 watchdog act=running exp=finished");
        summary();
    end

    initial begin
        logic [15:0] rd;
        int s0, p0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, rd); check("R1 status", 32'(rd), 32'd0);
        reg_read(2'd1, rd); check("R1 tx", 32'(rd), 32'd0);
        reg_read(2'd2, rd); check("R1 rx", 32'(rd), 32'd0);
        reg_read(2'd3, rd); check("R1 cmd", 32'(rd), 32'd0);
        check("R1 lines", {30'd0, scl_out, sda_out}, 32'd3);

        // R2 disabled core stays quiet with a pending command
        reg_write(2'd0, 16'h0001);
        reg_write(2'd1, 16'h0055);
        reg_write(2'd3, 16'h000B);
        s0 = n_start;
        repeat (100) @(negedge clk);
        check("R2 no start while disabled", 32'(n_start - s0), 32'd0);
        check("R2 lines released", {30'd0, scl_out, sda_out}, 32'd3);
        reg_read(2'd3, rd); check("R2 pending kept", 32'(rd), 32'h0B);

        // R3 zero write clears pending
        reg_write(2'd3, 16'h0000);
        reg_read(2'd3, rd); check("R3 pending cleared", 32'(rd), 32'd0);
        reg_write(2'd0, 16'h8001);
        repeat (100) @(negedge clk);
        check("R3 no activity after enable", 32'(n_start - s0), 32'd0);
        reg_read(2'd0, rd); check("R3 busy low", 32'(rd[14]), 32'd0);

        // R4 R5 R6 R7 combined start+write+stop table
        for (int i = 0; i < 4; i++) begin
            s0 = n_start; p0 = n_stop;
            slave_ack_drv = VEC[i][0];
            reg_write(2'd0, {8'h80, VEC[i][23:16]});
            reg_write(2'd1, {8'h00, VEC[i][15:8]});
            reg_write(2'd3, 16'h000B);
            wait_idle();
            check("R4 byte at slave", 32'(cap_byte), 32'(VEC[i][15:8]));
            check("R4 one start", 32'(n_start - s0), 32'd1);
            check("R5 scl period", 32'(period), 32'(4 * (VEC[i][23:16] + 1) + 1));
            reg_read(2'd0, rd);
            check("R6 ack flag", 32'(rd[13]), 32'(VEC[i][0]));
            check("R7 one stop", 32'(n_stop - p0), 32'd1);
            check("R7 lines idle", {30'd0, scl_out, sda_out}, 32'd3);
        end

        // R10 busy during a transfer
        reg_write(2'd0, 16'h8003);
        slave_ack_drv = 1'b0;
        reg_write(2'd1, 16'h00A0);
        reg_write(2'd3, 16'h0009);
        reg_read(2'd0, rd); check("R10 busy after write", 32'(rd[14]), 32'd1);
        repeat (30) @(negedge clk);
        reg_read(2'd0, rd); check("R10 busy mid byte", 32'(rd[14]), 32'd1);
        wait_idle();
        reg_read(2'd0, rd); check("R10 busy cleared", 32'(rd[14]), 32'd0);
        check("R9 scl held low", 32'(scl_out), 32'd0);

        // address byte, then repeated start
        reg_write(2'd1, 16'h0012);
        reg_write(2'd3, 16'h0008);
        wait_idle();
        s0 = n_start; p0 = n_stop;
        reg_write(2'd1, 16'h00A1);
        reg_write(2'd3, 16'h0009);
        wait_idle();
        check("R9 repeated start seen", 32'(n_start - s0), 32'd1);
        check("R9 no stop between", 32'(n_stop - p0), 32'd0);
        check("R9 address byte", 32'(cap_byte), 32'hA1);

        // R8 read with nack and stop
        slave_tx = 8'h6B;
        rd_req = rd_req + 1;
        reg_write(2'd3, 16'h0016);
        wait_idle();
        reg_read(2'd2, rd); check("R8 rx byte", 32'(rd), 32'h6B);
        check("R8 master nack", 32'(master_ack), 32'd1);
        check("R8 stop after read", 32'(n_stop - p0), 32'd1);

        // R8 read with ack level 0
        reg_write(2'd1, 16'h00A1);
        reg_write(2'd3, 16'h0009);
        wait_idle();
        slave_tx = 8'h94;
        rd_req = rd_req + 1;
        reg_write(2'd3, 16'h0006);
        wait_idle();
        reg_read(2'd2, rd); check("R8 rx byte 2", 32'(rd), 32'h94);
        check("R8 master ack", 32'(master_ack), 32'd0);

        // R12 ignored writes
        reg_write(2'd2, 16'h00FF);
        reg_read(2'd2, rd); check("R12 rx write ignored", 32'(rd), 32'h94);
        reg_write(2'd0, 16'hE001);
        reg_read(2'd0, rd); check("R12 status bits ignored", 32'(rd), 32'h8001);
        reg_write(2'd1, 16'h0077);
        reg_write(2'd3, 16'h000B);
        wait_idle();
        reg_read(2'd2, rd); check("R12 rx kept on write", 32'(rd), 32'h94);
        check("R11 lines idle", {30'd0, scl_out, sda_out}, 32'd3);

        summary();
    end
endmodule